// File: doc/BRIEF.md
# Seven-Bag Tetromino Sequence Generator

This block deals the stream of falling-piece type codes for a block-stacking game. Pieces are dealt in bags: every bag holds each of the seven shapes exactly once, and the draw order inside a bag comes from a free-running random value supplied from outside. The block keeps a lookahead queue of upcoming pieces, the piece now in play, and a single hold slot that the player may use once per spawned piece.

After reset the block fills itself. It draws one piece per cycle until the active slot and every preview slot hold a real type, and then raises `primed_o`. From then on, a next request promotes the head of the queue to active and draws one fresh type into the tail. A hold request either stashes the active piece, if the hold slot is empty, or exchanges it with the held one. The surrounding game logic reads all slots as 4-bit codes. Code 0 means empty and codes 1 to 7 are the seven shapes.

Top module: `piece_bag_gen`

## Requirements
- R1: Each run of seven consecutive draws that starts at the beginning of a bag contains every code 1..7 exactly once; code 0 is never drawn.
- R2: A draw takes k = rnd_i mod (7 − types already dealt in the bag) and returns the k-th not-yet-dealt code, counting from 0 upward from the lowest code.
- R3: At the draw that deals the seventh type of a bag, the dealt record and position counter clear, so the next draw starts a fresh bag.
- R4: While reset is asserted, active_o, held_o and preview_o read 0 and primed_o is low. After reset is released, 5 fill cycles follow. When they end, primed_o is high, active_o holds the first draw and preview slot i holds draw i+2.
- R5: With primed_o high, next_i promotes preview slot 0 to active, shifts slots up by one, puts a fresh draw in slot 3, and re-enables hold. The result is visible after the next clock edge.
- R6: A permitted hold with held_o = 0 moves the active type to held_o, promotes slot 0 to active, shifts the queue and draws a fresh type into slot 3.
- R7: A permitted hold with held_o ≠ 0 exchanges the active and held types and leaves the queue and the bag untouched; held_o never returns to 0 except through reset.
- R8: After a hold, further hold requests change nothing at the ports until a next request is accepted.
- R9: next_i and hold_i are ignored while primed_o is low. When both are high in the same cycle, only the next request is performed.
- R10: preview_o packs slot i, with slot 0 the next to be played, at bits [4i+3:4i]; idle cycles change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rnd_i | input | RAND_W (8) | Free-running random value, sampled on each draw |
| next_i | input | 1 | Request the next piece |
| hold_i | input | 1 | Request a hold stash or swap |
| primed_o | output | 1 | Queue and active slot are filled |
| active_o | output | CODE_W (4) | Type code of the piece in play |
| held_o | output | CODE_W (4) | Type code in the hold slot, 0 when empty |
| preview_o | output | PREVIEW_DEPTH*CODE_W (16) | Packed preview queue, slot 0 in the low nibble |

## Verification
A corrupted dealt record or position counter shows first in the tail preview slot. The next draw lands there one edge after the request, as a repeated shape or as a bag that lacks one. It reaches active_o four requests later. A faulty hold-lock or swap path shows at active_o and held_o on the very edge after the request. The bench carries an arithmetic model of the bag and the queue, and compares every output port on every cycle across long mixed request sweeps, including constant-zero and constant-maximum random inputs and a reset during play.

// File: rtl/piece_bag_pkg.sv
package piece_bag_pkg;
   // operation chosen by the top for the current cycle
   typedef enum logic [1:0] {
      OP_IDLE    = 2'd0,
      OP_ADVANCE = 2'd1,
      OP_STASH   = 2'd2,
      OP_SWAP    = 2'd3
   } bag_op_e;
endpackage

// File: rtl/kth_free_select.sv
module kth_free_select #(
   parameter int N  = 7,
   parameter int KW = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  taken_i,
   input  logic [KW-1:0] rank_i,
   output logic [N-1:0]  pick_o,
   output logic [IW-1:0] idx_o,
   output logic          found_o
);
   // number of free entries strictly below position i
   logic [KW:0] below [0:N];

   assign below[0] = '0;

   for (genvar i = 0; i < N; i++) begin : g_pos
      assign below[i+1] = below[i] + {{KW{1'b0}}, ~taken_i[i]};
      assign pick_o[i]  = ~taken_i[i] & (below[i] == {1'b0, rank_i});
   end

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (pick_o[i]) idx_o = IW'(i);
      end
   end

   assign found_o = |pick_o;
endmodule

// File: rtl/bag_tracker.sv
module bag_tracker #(
   parameter int N      = 7,
   parameter int RAND_W = 8,
   parameter int CODE_W = 4,
   localparam int CNT_W = $clog2(N + 1),
   localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [RAND_W-1:0] rnd_i,
   input  logic              draw_i,
   output logic [CODE_W-1:0] code_o
);
   logic [N-1:0]      dealt_q;
   logic [CNT_W-1:0]  count_q;
   logic [CNT_W-1:0]  left;
   logic [RAND_W-1:0] rank;
   logic [N-1:0]      pick;
   logic [IW-1:0]     idx;
   logic              found;
   logic              last;

   assign left = CNT_W'(N) - count_q;
   assign rank = rnd_i % RAND_W'(left);
   assign last = (count_q == CNT_W'(N - 1));

   kth_free_select #(.N(N), .KW(RAND_W)) u_pick (
      .taken_i (dealt_q),
      .rank_i  (rank),
      .pick_o  (pick),
      .idx_o   (idx),
      .found_o (found)
   );

   assign code_o = CODE_W'(idx) + CODE_W'(1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dealt_q <= '0;
         count_q <= '0;
      end else if (draw_i) begin
         if (last) begin
            dealt_q <= '0;
            count_q <= '0;
         end else begin
            dealt_q <= dealt_q | pick;
            count_q <= count_q + CNT_W'(1);
         end
      end
   end

   assert_pick_fresh_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      draw_i |-> (found && ((pick & dealt_q) == '0)));
   assert_single_pick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      draw_i |-> $onehot(pick));
   assert_tally_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($countones(dealt_q) == int'(count_q)) && (int'(count_q) < N));
   assert_bag_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (draw_i && last) |=> (dealt_q == '0 && count_q == '0));
endmodule

// File: rtl/preview_queue.sv
module preview_queue #(
   parameter int DEPTH  = 4,
   parameter int CODE_W = 4,
   localparam int QW    = DEPTH * CODE_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              shift_i,
   input  logic [CODE_W-1:0] fill_i,
   output logic [CODE_W-1:0] head_o,
   output logic [QW-1:0]     flat_o
);
   logic [QW-1:0] slots_q;

   if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      slots_q <= '0;
         else if (shift_i) slots_q <= fill_i;
      end
   end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      slots_q <= '0;
         else if (shift_i) slots_q <= {fill_i, slots_q[QW-1:CODE_W]};
      end
   end

   assign head_o = slots_q[CODE_W-1:0];
   assign flat_o = slots_q;

   assert_tail_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shift_i |=> (slots_q[QW-1 -: CODE_W] == $past(fill_i)));
   assert_hold_still_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !shift_i |=> $stable(slots_q));
endmodule

// File: rtl/piece_bag_gen.sv
module piece_bag_gen
   import piece_bag_pkg::*;
#(
   parameter int NUM_TYPES     = 7,
   parameter int PREVIEW_DEPTH = 4,
   parameter int CODE_W        = 4,
   parameter int RAND_W        = 8
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic [RAND_W-1:0]               rnd_i,
   input  logic                            next_i,
   input  logic                            hold_i,
   output logic                            primed_o,
   output logic [CODE_W-1:0]               active_o,
   output logic [CODE_W-1:0]               held_o,
   output logic [PREVIEW_DEPTH*CODE_W-1:0] preview_o
);
   localparam int FILL_N = PREVIEW_DEPTH + 1;
   localparam int FILL_W = $clog2(FILL_N + 1);

   initial begin
      assert (NUM_TYPES >= 2) else $error("NUM_TYPES must be at least 2");
      assert (PREVIEW_DEPTH >= 1) else $error("PREVIEW_DEPTH must be at least 1");
      assert (CODE_W >= $clog2(NUM_TYPES + 1)) else $error("CODE_W too narrow");
      assert (RAND_W >= $clog2(NUM_TYPES + 1)) else $error("RAND_W too narrow");
   end

   logic [FILL_W-1:0] fill_q;
   logic [CODE_W-1:0] active_q;
   logic [CODE_W-1:0] held_q;
   logic              hold_used_q;
   logic              primed;
   logic              advance;
   logic [CODE_W-1:0] fresh;
   logic [CODE_W-1:0] head;
   bag_op_e           op;

   assign primed = (fill_q == FILL_W'(FILL_N));

   always_comb begin
      if (!primed)                    op = OP_ADVANCE;
      else if (next_i)                op = OP_ADVANCE;
      else if (hold_i && !hold_used_q) op = (held_q == '0) ? OP_STASH : OP_SWAP;
      else                            op = OP_IDLE;
   end

   assign advance = (op == OP_ADVANCE) || (op == OP_STASH);

   bag_tracker #(.N(NUM_TYPES), .RAND_W(RAND_W), .CODE_W(CODE_W)) u_bag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rnd_i  (rnd_i),
      .draw_i (advance),
      .code_o (fresh)
   );

   preview_queue #(.DEPTH(PREVIEW_DEPTH), .CODE_W(CODE_W)) u_queue (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .shift_i (advance),
      .fill_i  (fresh),
      .head_o  (head),
      .flat_o  (preview_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fill_q      <= '0;
         active_q    <= '0;
         held_q      <= '0;
         hold_used_q <= 1'b0;
      end else begin
         case (op)
            OP_ADVANCE: begin
               active_q    <= head;
               hold_used_q <= 1'b0;
               if (!primed) fill_q <= fill_q + FILL_W'(1);
            end
            OP_STASH: begin
               held_q      <= active_q;
               active_q    <= head;
               hold_used_q <= 1'b1;
            end
            OP_SWAP: begin
               held_q      <= active_q;
               active_q    <= held_q;
               hold_used_q <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign primed_o = primed;
   assign active_o = active_q;
   assign held_o   = held_q;

   assert_promote_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (primed && next_i) |=> (active_o == $past(preview_o[CODE_W-1:0])));
   assert_swap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (primed && !next_i && hold_i && !hold_used_q && held_q != '0)
      |=> (held_o == $past(active_o) && active_o == $past(held_o)));
   assert_held_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (held_o != '0) |=> (held_o != '0));
   assert_hold_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (primed && !next_i && hold_used_q) |=> ($stable(held_o) && $stable(active_o)));
   assert_primed_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      primed_o |=> primed_o);
   assert_types_valid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      primed_o |-> (active_o != '0 && int'(active_o) <= NUM_TYPES));
endmodule

// File: tb/piece_bag_gen_tb_top.sv
module piece_bag_gen_tb_top;
   localparam int CLK_P = 10;
   localparam int DEPTH = 4;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic [7:0]  rnd_i = '0;
   logic        next_i = 1'b0;
   logic        hold_i = 1'b0;
   logic        primed_o;
   logic [3:0]  active_o;
   logic [3:0]  held_o;
   logic [15:0] preview_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model state
   int m_q [DEPTH];
   int m_active, m_held, m_fill;
   bit m_used, m_primed;
   bit [6:0] m_rec;
   int m_cnt;
   bit [6:0] bag_seen;
   int bag_n;

   always #(CLK_P/2) clk_i = ~clk_i;

   piece_bag_gen dut_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rnd_i     (rnd_i),
      .next_i    (next_i),
      .hold_i    (hold_i),
      .primed_o  (primed_o),
      .active_o  (active_o),
      .held_o    (held_o),
      .preview_o (preview_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < DEPTH; i++) m_q[i] = 0;
      m_active = 0; m_held = 0; m_fill = 0;
      m_used = 0; m_primed = 0;
      m_rec = '0; m_cnt = 0;
      bag_seen = '0; bag_n = 0;
   endtask

   // R2: k = r mod remaining, k-th free code counted from the lowest
   task automatic model_draw(input int r, output int code);
      int rem, k, seen;
      rem = 7 - m_cnt;
      k = r % rem;
      seen = 0;
      code = 0;
      for (int i = 0; i < 7; i++) begin
         if (!m_rec[i]) begin
            if (seen == k && code == 0) code = i + 1;
            seen++;
         end
      end
      m_rec[code-1] = 1'b1;
      m_cnt++;
      if (m_cnt == 7) begin m_rec = '0; m_cnt = 0; end   // R3 wrap
      bag_seen[code-1] = 1'b1;
      bag_n++;
      if (bag_n == 7) begin
         chk(bag_seen == 7'h7F, "R1 bag content", int'(bag_seen), 127);
         bag_seen = '0;
         bag_n = 0;
      end
   endtask

   task automatic model_shift_draw(input int r);
      int c;
      m_active = m_q[0];
      for (int i = 0; i < DEPTH - 1; i++) m_q[i] = m_q[i+1];
      model_draw(r, c);
      m_q[DEPTH-1] = c;
   endtask

   function automatic int exp_flat();
      int f = 0;
      for (int i = 0; i < DEPTH; i++) f = f | (m_q[i] << (4*i));
      return f;
   endfunction

   task automatic compare(input string tag);
      chk(primed_o == m_primed, {tag, " primed"}, int'(primed_o), int'(m_primed));
      chk(int'(active_o) == m_active, {tag, " active"}, int'(active_o), m_active);
      chk(int'(held_o) == m_held, {tag, " held"}, int'(held_o), m_held);
      chk(int'(preview_o[15:12]) == m_q[3], "R2 fresh draw in slot 3", int'(preview_o[15:12]), m_q[3]);
      chk(int'(preview_o) == exp_flat(), {tag, " R10 preview"}, int'(preview_o), exp_flat());
   endtask

   // one cycle: drive at negedge, model the edge, compare at the next negedge
   task automatic cycle(input int r, input bit nx, input bit hd);
      string tag;
      int t;
      rnd_i = 8'(r);
      next_i = nx;
      hold_i = hd;
      if (!m_primed) begin
         tag = (nx || hd) ? "R9 ignored during fill" : "R4 fill";
         model_shift_draw(r);
         m_used = 0;
         m_fill++;
         if (m_fill == DEPTH + 1) m_primed = 1;
      end else if (nx) begin
         tag = hd ? "R9 next wins" : "R5 next";
         model_shift_draw(r);
         m_used = 0;
      end else if (hd && !m_used) begin
         if (m_held == 0) begin
            tag = "R6 stash";
            m_held = m_active;
            model_shift_draw(r);
         end else begin
            tag = "R7 swap";
            t = m_active; m_active = m_held; m_held = t;
         end
         m_used = 1;
      end else if (hd) begin
         tag = "R8 hold locked";
      end else begin
         tag = "R10 idle";
      end
      @(posedge clk_i);
      @(negedge clk_i);
      compare(tag);
   endtask

   task automatic reset_check();
      rst_ni = 1'b0;
      next_i = 1'b0;
      hold_i = 1'b0;
      @(negedge clk_i);
      @(negedge clk_i);
      model_reset();
      chk(primed_o == 1'b0, "R4 reset primed", int'(primed_o), 0);
      chk(active_o == '0, "R4 reset active", int'(active_o), 0);
      chk(held_o == '0, "R4 reset held", int'(held_o), 0);
      chk(preview_o == '0, "R4 reset preview", int'(preview_o), 0);
      rst_ni = 1'b1;
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk_i);
      reset_check();
      // fill with requests asserted, which must be ignored (R9)
      for (int i = 0; i < DEPTH + 1; i++) cycle(i * 3 + 1, i[0], 1'b1);
      chk(primed_o == 1'b1, "R4 primed after fill", int'(primed_o), 1);
      chk(int'(preview_o[3:0]) == m_q[0], "R10 slot 0 packing", int'(preview_o[3:0]), m_q[0]);

      // constant zero random: always the lowest free code (R2)
      for (int i = 0; i < 21; i++) cycle(0, 1'b1, 1'b0);
      // constant maximum random
      for (int i = 0; i < 21; i++) cycle(255, 1'b1, 1'b0);

      // hold sequences: stash, locked, next, swap, locked
      cycle(5, 1'b0, 1'b1);
      cycle(6, 1'b0, 1'b1);
      cycle(7, 1'b1, 1'b0);
      cycle(8, 1'b0, 1'b1);
      cycle(9, 1'b0, 1'b1);
      cycle(10, 1'b1, 1'b1);

      // mixed sweep over random values and request patterns
      for (int i = 0; i < 1400; i++) begin
         int sel;
         int r;
         sel = (i * 7 + i / 3) % 6;
         r = (i * 53 + (i >> 2) * 17) & 255;
         case (sel)
            0: cycle(r, 1'b1, 1'b0);
            1: cycle(r, 1'b0, 1'b1);
            2: cycle(r, 1'b0, 1'b1);
            3: cycle(r, 1'b1, 1'b1);
            4: cycle(r, 1'b0, 1'b0);
            default: cycle(r, 1'b1, 1'b0);
         endcase
      end

      // reset in the middle of play, then refill and run again
      @(negedge clk_i);
      reset_check();
      for (int i = 0; i < DEPTH + 1; i++) cycle(200 + i, 1'b0, 1'b0);
      for (int i = 0; i < 300; i++) cycle((i * 29 + 3) & 255, (i % 3) != 2, (i % 4) == 1);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule